// File: doc/BRIEF.md
# Mixed-Trigger Interrupt Controller

This block gathers 32 interrupt sources into one interrupt line toward a processor. Each source position has a fixed trigger kind. Level positions pass their sampled input straight into the status vector. Edge positions catch a rising input in a sticky latch, and the latch holds until software clears it. Three of the edge positions can also be raised by software through a dedicated register. Three of the level positions carry the summary lines of a downstream peripheral controller: audio on bit 6, miscellaneous on bit 5 and serial/parallel on bit 4. Bits 8 to 15 carry peripheral-bus sources. These are already gated by their own enables before they reach this block.

Software reaches four registers through a simple port. The port has a write strobe, a read strobe, a 2-bit register select and 32-bit data. A source counts as pending when its status bit and its mask bit are both 1. The output is the OR of all pending sources, taken through one register stage.

Top module: `mixed_irq_ctrl`

## Requirements
- R1: After reset, `irq_o` is 0, and the mask (select 1), latch (select 2) and software (select 3) registers all read as 0.
- R2: A source whose mask bit is 0 never raises `irq_o`. Its status bit (select 0, bit i = source i) still shows the raw state.
- R3: Level positions are bits 0-15, 20, 21, 25-27 and 31, including the peripheral summaries on bits 4-6. Their status bits follow the input, and `irq_o` drops once such an input falls.
- R4: Edge positions are bits 16-19, 22-24 and 28-30. A 0-to-1 change on one of these inputs sets its latch bit, and the bit stays set after the input returns to 0.
- R5: A write to select 2 clears each latch bit written as 0 and leaves each latch bit written as 1 unchanged.
- R6: When a new rising edge arrives in the same cycle as a write that clears that bit, the rising edge wins and the bit stays set.
- R7: The software register (select 3) stores only bits 28-30; all other bits read 0. A 0-to-1 change of a stored bit sets the matching latch bit.
- R8: A latch bit is set only by a rising change. An input held high after its bit has been cleared does not set the bit again.
- R9: `irq_o` is the OR of (status AND mask), registered. After a mask write, `irq_o` changes one cycle later, not in the same cycle.
- R10: Select 0 is read-only, and writes to it change no register. Read data appears on `rd_data_o` in the cycle after `rd_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_irq_i | input | 32 | Raw source lines, bit i = source i |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register select: 0 status, 1 mask, 2 latch, 3 software |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Registered read data |
| irq_o | output | 1 | Merged interrupt request |

## Verification
The bench lines up a fresh rising edge with a clearing write in the same cycle. A design that let the write win would lose that interrupt. It holds an edge input high across a clear. A design that treated the position as a level would fire again at once. It checks the exact cycle in which `irq_o` follows a mask write, which catches a missing or extra register stage. It also writes ones to the read-only status select and to the non-software bits of the software register, which exposes a decode that lets those writes reach the mask or the latch.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned SRC_N  = 32;
  localparam int unsigned REG_AW = 2;
  // positions that are caught on a rising change
  localparam logic [SRC_N-1:0] EDGE_BITS = 32'h71CF_0000;
  // positions software may raise
  localparam logic [SRC_N-1:0] SOFT_BITS = 32'h7000_0000;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_LATCH  = 2'd2,
    SEL_SOFT   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irqc_capture.sv
module irqc_capture #(
  parameter int unsigned             N    = irqc_pkg::SRC_N,
  parameter logic [N-1:0]            EDGE = irqc_pkg::EDGE_BITS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] line_i,
  input  logic [N-1:0] soft_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] samp_q;
  logic [N-1:0] src;

  always_ff @(posedge clk) begin
    if (rst) samp_q <= '0;
    else     samp_q <= line_i;
  end

  assign src = samp_q | soft_i;

  for (genvar i = 0; i < N; i++) begin : g_bit
    if (EDGE[i]) begin : g_edge
      logic prev_b;
      always_ff @(posedge clk) begin
        if (rst) prev_b <= 1'b0;
        else     prev_b <= src[i];
      end
      assign rise_o[i]  = src[i] & ~prev_b;
      assign level_o[i] = 1'b0;
    end else begin : g_level
      assign rise_o[i]  = 1'b0;
      assign level_o[i] = src[i];
    end
  end

  // R4: a rise pulse never appears on a level position
  p_rise_edge_only_r4: assert property (@(posedge clk) disable iff (rst)
    (rise_o & ~EDGE) == '0);
endmodule

// File: rtl/irqc_latch.sv
module irqc_latch #(
  parameter int unsigned N = irqc_pkg::SRC_N
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] rise_i,
  input  logic         clr_en_i,
  input  logic [N-1:0] keep_i,
  output logic [N-1:0] latch_o
);
  logic [N-1:0] latch_q;
  logic [N-1:0] kept;

  assign kept = clr_en_i ? (latch_q & keep_i) : latch_q;

  always_ff @(posedge clk) begin
    if (rst) latch_q <= '0;
    else     latch_q <= kept | rise_i;
  end

  assign latch_o = latch_q;

  // R4: without a clearing write, set bits stay set
  p_sticky_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !clr_en_i |=> ((latch_q & $past(latch_q)) == $past(latch_q)));

  // R8: a bit turns on only after a rise pulse
  p_set_needs_rise_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((latch_q & ~$past(latch_q) & ~$past(rise_i)) == '0));

  // R6: a rise in the clearing cycle survives
  p_clear_race_r6: assert property (@(posedge clk) disable iff (rst)
    clr_en_i |=> (($past(rise_i) & ~latch_q) == '0));
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs #(
  parameter int unsigned  N    = irqc_pkg::SRC_N,
  parameter int unsigned  AW   = irqc_pkg::REG_AW,
  parameter logic [N-1:0] SOFT = irqc_pkg::SOFT_BITS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [N-1:0]  wdata_i,
  input  logic [N-1:0]  status_i,
  input  logic [N-1:0]  latch_i,
  output logic [N-1:0]  mask_o,
  output logic [N-1:0]  soft_o,
  output logic          clr_en_o,
  output logic [N-1:0]  keep_o,
  output logic [N-1:0]  rdata_o
);
  import irqc_pkg::*;

  localparam logic [AW-1:0] A_STATUS = AW'(SEL_STATUS);
  localparam logic [AW-1:0] A_MASK   = AW'(SEL_MASK);
  localparam logic [AW-1:0] A_LATCH  = AW'(SEL_LATCH);
  localparam logic [AW-1:0] A_SOFT   = AW'(SEL_SOFT);

  logic [N-1:0] mask_q;
  logic [N-1:0] soft_q;
  logic [N-1:0] rd_q;
  logic [N-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      soft_q <= '0;
    end else if (wr_en_i) begin
      if (addr_i == A_MASK) mask_q <= wdata_i;
      if (addr_i == A_SOFT) soft_q <= wdata_i & SOFT;
    end
  end

  always_comb begin
    unique case (addr_i)
      A_STATUS: rd_mux = status_i;
      A_MASK:   rd_mux = mask_q;
      A_LATCH:  rd_mux = latch_i;
      A_SOFT:   rd_mux = soft_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          rd_q <= '0;
    else if (rd_en_i) rd_q <= rd_mux;
  end

  assign mask_o   = mask_q;
  assign soft_o   = soft_q;
  assign clr_en_o = wr_en_i && (addr_i == A_LATCH);
  assign keep_o   = wdata_i;
  assign rdata_o  = rd_q;

  // R7: only the software positions can hold a 1
  p_soft_field_r7: assert property (@(posedge clk) disable iff (rst)
    (soft_q & ~SOFT) == '0);

  // R10: a write to the status select leaves the mask alone
  p_status_ro_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i == A_STATUS) |=> (mask_q == $past(mask_q)));
endmodule

// File: rtl/mixed_irq_ctrl.sv
module mixed_irq_ctrl #(
  parameter int unsigned N  = irqc_pkg::SRC_N,
  parameter int unsigned AW = irqc_pkg::REG_AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  dev_irq_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [N-1:0]  wr_data_i,
  output logic [N-1:0]  rd_data_o,
  output logic          irq_o
);
  localparam logic [N-1:0] EDGE_SEL = N'(irqc_pkg::EDGE_BITS);
  localparam logic [N-1:0] SOFT_SEL = N'(irqc_pkg::SOFT_BITS);

  logic [N-1:0] level_v, rise_v, latch_v, status_v;
  logic [N-1:0] mask_v, soft_v, keep_v;
  logic         clr_en;
  logic         irq_q;

  irqc_capture #(.N(N), .EDGE(EDGE_SEL)) u_capture (
    .clk     (clk),
    .rst     (rst),
    .line_i  (dev_irq_i),
    .soft_i  (soft_v),
    .level_o (level_v),
    .rise_o  (rise_v)
  );

  irqc_latch #(.N(N)) u_latch (
    .clk      (clk),
    .rst      (rst),
    .rise_i   (rise_v),
    .clr_en_i (clr_en),
    .keep_i   (keep_v),
    .latch_o  (latch_v)
  );

  assign status_v = level_v | latch_v;

  irqc_regs #(.N(N), .AW(AW), .SOFT(SOFT_SEL)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wr_data_i),
    .status_i (status_v),
    .latch_i  (latch_v),
    .mask_o   (mask_v),
    .soft_o   (soft_v),
    .clr_en_o (clr_en),
    .keep_o   (keep_v),
    .rdata_o  (rd_data_o)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(status_v & mask_v);
  end

  assign irq_o = irq_q;

  // R2: with nothing unmasked the line stays low
  p_masked_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (mask_v == '0) |=> !irq_o);

  // R9: a raised line always has some unmasked status behind it
  p_irq_has_cause_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> ($past(status_v & mask_v) != '0));
endmodule

// File: tb/mixed_irq_ctrl_bench.sv
module mixed_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] dev = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mixed_irq_ctrl u_mixed_irq_ctrl (
    .clk(clk), .rst(rst), .dev_irq_i(dev), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wr_data_i(wdata), .rd_data_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(2'd1, v); chk("R1 mask", v, 32'h0);
    rd(2'd2, v); chk("R1 latch", v, 32'h0);
    rd(2'd3, v); chk("R1 soft", v, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] v;
    wr(2'd1, 32'hFFFF_FFFF);
    dev[3] = 1'b1; settle();
    chk("R3 irq level", {31'b0, irq}, 32'h1);
    rd(2'd0, v); chk("R3 status level", v, 32'h0000_0008);
    dev[3] = 1'b0; dev[5] = 1'b1; settle();
    rd(2'd0, v); chk("R3 cascade status", v, 32'h0000_0020);
    dev[5] = 1'b0; settle();
    chk("R3 irq drops", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(2'd1, ~32'h0000_0200);
    dev[9] = 1'b1; settle();
    chk("R2 masked irq", {31'b0, irq}, 32'h0);
    rd(2'd0, v); chk("R2 raw status", v, 32'h0000_0200);
    // R9: exact cycle of response to mask write
    @(negedge clk);
    wr_en = 1'b1; addr = 2'd1; wdata = 32'hFFFF_FFFF;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R9 same cycle", {31'b0, irq}, 32'h0);
    @(posedge clk); @(negedge clk);
    chk("R9 next cycle", {31'b0, irq}, 32'h1);
    dev[9] = 1'b0; settle();
  endtask

  task automatic t_edge_clear();
    logic [31:0] v;
    dev[17] = 1'b1; dev[23] = 1'b1; settle();
    dev[17] = 1'b0; dev[23] = 1'b0; settle();
    chk("R4 irq sticky", {31'b0, irq}, 32'h1);
    rd(2'd2, v); chk("R4 latch sticky", v, 32'h0082_0000);
    wr(2'd2, ~32'h0002_0000);
    rd(2'd2, v); chk("R5 partial clear", v, 32'h0080_0000);
    wr(2'd2, ~32'h0080_0000);
    rd(2'd2, v); chk("R5 full clear", v, 32'h0);
    @(negedge clk);
    chk("R5 irq low", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_no_retrigger();
    logic [31:0] v;
    dev[18] = 1'b1; settle();
    wr(2'd2, 32'h0); settle();
    rd(2'd2, v); chk("R8 held high no reset", v, 32'h0);
    chk("R8 irq low", {31'b0, irq}, 32'h0);
    dev[18] = 1'b0; settle();
  endtask

  task automatic t_race();
    logic [31:0] v;
    dev[16] = 1'b1; dev[19] = 1'b1; settle();
    dev[16] = 1'b0; dev[19] = 1'b0; settle();
    @(negedge clk);
    dev[16] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b1; addr = 2'd2; wdata = 32'h0;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    rd(2'd2, v); chk("R6 edge beats clear", v, 32'h0001_0000);
    dev[16] = 1'b0; settle();
    wr(2'd2, 32'h0);
  endtask

  task automatic t_soft();
    logic [31:0] v;
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, v); chk("R7 soft field", v, 32'h7000_0000);
    settle();
    rd(2'd2, v); chk("R7 soft sets latch", v, 32'h7000_0000);
    chk("R7 irq", {31'b0, irq}, 32'h1);
    wr(2'd2, 32'h0); settle();
    rd(2'd2, v); chk("R8 soft no retrigger", v, 32'h0);
    wr(2'd3, 32'h0);
    wr(2'd3, 32'h2000_0000); settle();
    rd(2'd2, v); chk("R7 single soft bit", v, 32'h2000_0000);
    wr(2'd3, 32'h0);
    wr(2'd2, 32'h0);
  endtask

  task automatic t_status_ro();
    logic [31:0] v;
    wr(2'd1, 32'h0000_00F0);
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd1, v); chk("R10 mask untouched", v, 32'h0000_00F0);
    rd(2'd0, v); chk("R10 status untouched", v, 32'h0);
    rd(2'd2, v); chk("R10 latch untouched", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_level();
    t_mask();
    t_edge_clear();
    t_no_retrigger();
    t_race();
    t_soft();
    t_status_ro();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule